// File: doc/BRIEF.md
# Chained Serial Configuration Forwarder

This block sits in every device of a serial configuration chain that shares one test clock. A single bitstream enters the first device on `tdi`. Each device looks for a fixed start pattern and reads a length word. It repeats both onto `tdo` so that every device further down the chain sees the same header. It then takes in its own fixed number of data frames, and for each frame it presents the payload with a one-cycle strobe to the local configuration memory. While it takes in those frames it keeps `tdo` at logic high, so a device further down never sees a frame start that is not meant for it. Once its own frames are complete it raises `done` and becomes a transparent one-stage pipe: each later bit is sampled on the rising edge and driven out on the next falling edge.

Configuration is always accepted after reset. A later reconfiguration request restarts the block only when the chain-enable input is set. Otherwise the block locks up: it ignores `tdi` and keeps `tdo` high until the next reset or an enabled request.

Top module: `cfg_chain_fwd`

## Requirements
- R1: After reset is released the block drives `tdo`=1, `done`=0, `frame_err`=0 and `frame_valid`=0, and it searches for the start pattern.
- R2: `tdi` is sampled on the rising edge of `tck`. A bit that is forwarded appears on `tdo` at the next falling edge, so it is one `tck` period behind the input.
- R3: While searching, the 8-bit pattern 1111_0010 (first bit received is the leftmost) is recognised. The next `LEN_BITS` bits (24 by default) form the length word, most significant bit first, which is shown on `len_count`. The pattern, the length word and the idle bits before them are all forwarded on `tdo`.
- R4: From the bit after the last length bit through the second stop bit of the last local frame, `tdo` is 1. A downstream device therefore never sees a frame start before all upstream devices have raised `done`.
- R5: A local frame is a 0 followed by a 1, then `FRAME_BITS` payload bits (the first received bit goes to the MSB of `frame_data`), then a stop pair 1,1. Ones that arrive while the block waits for a frame are idle and ignored.
- R6: `frame_valid` is high for exactly one `tck` cycle. It is raised by the rising edge that samples the second stop bit, and `frame_data` then holds that frame's payload.
- R7: After `NUM_FRAMES` good frames, `done` goes to 1 and stays there. Every later `tdi` bit is then forwarded to `tdo` as described in R2.
- R8: Any of these raises the sticky `frame_err` and stops the loading: a 0 in place of the second start bit, a 0 in either stop position. From then on there is no further `frame_valid`, `done` stays 0 and `tdo` stays 1.
- R9: A `reconf_req` pulse with `chain_en`=1 clears `done`, `frame_err` and the frame count, and restarts the start-pattern search. With `chain_en`=0 the block locks instead: it ignores `tdi`, drives `tdo`=1, gives no `frame_valid` and keeps `done` at 0.
- R10: Pulling `rst_n` low takes effect at once, without waiting for a clock edge. It gives `tdo`=1, `done`=0, `frame_err`=0 and `frame_valid`=0, and it clears a sticky error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Serial test clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on or program reset) |
| chain_en | input | 1 | Allows a reconfiguration through the chain |
| reconf_req | input | 1 | One-cycle reconfiguration request, sampled on the rising edge |
| tdi | input | 1 | Serial bitstream input |
| tdo | output | 1 | Serial output towards the next device, updated on the falling edge |
| frame_valid | output | 1 | One-cycle strobe for a completed local frame |
| frame_data | output | FRAME_BITS | Payload of the frame being strobed |
| len_count | output | LEN_BITS | Captured length word |
| done | output | 1 | All local frames have been received |
| frame_err | output | 1 | Sticky framing error |

## Verification
Three instances with 2, 3 and 1 local frames are wired in series. They are driven with random payloads, random length words, random idle gaps between frames and random trailing bits, and a near-miss decoy pattern comes before each real start pattern. These streams show whether each device picks out exactly its own frames in order and whether the first device masks exactly the span from the header's end to its last stop bit. Directed streams with a broken second start bit, a broken stop bit, a locked reconfiguration and an asynchronous reset in the middle of an error each exercise one way the loading can stop. They show whether the block holds `tdo` high and stays silent, or starts over cleanly.

// File: rtl/cfg_chain_fwd.sv
module cfg_chain_fwd #(
  parameter int FRAME_BITS = 64,
  parameter int NUM_FRAMES = 4,
  parameter int LEN_BITS   = 24,
  parameter int PRE_BITS   = 8,
  parameter logic [PRE_BITS-1:0] PREAMBLE = 8'b1111_0010
) (
  input  logic                  tck,
  input  logic                  rst_n,
  input  logic                  chain_en,
  input  logic                  reconf_req,
  input  logic                  tdi,
  output logic                  tdo,
  output logic                  frame_valid,
  output logic [FRAME_BITS-1:0] frame_data,
  output logic [LEN_BITS-1:0]   len_count,
  output logic                  done,
  output logic                  frame_err
);
  localparam int PCW = $clog2(FRAME_BITS + 1);
  localparam int LCW = $clog2(LEN_BITS + 1);
  localparam int FCW = $clog2(NUM_FRAMES + 1);

  typedef enum logic [2:0] {S_SEARCH, S_LEN, S_FRAME, S_PASS, S_ERR, S_LOCK} st_t;
  typedef enum logic [2:0] {P_IDLE, P_START, P_PAY, P_STOP0, P_STOP1} ph_t;

  st_t                 st;
  ph_t                 ph;
  logic [PRE_BITS-2:0] pre_sr;
  logic [LEN_BITS-2:0] len_sh;
  logic [LCW-1:0]      len_cnt;
  logic [PCW-1:0]      pay_cnt;
  logic [FCW-1:0]      frm_cnt;
  logic                fwd_bit;
  logic                tdo_q;

  wire [PRE_BITS-1:0] pre_next   = {pre_sr, tdi};
  wire                pass_now   = (st == S_SEARCH) || (st == S_LEN) || (st == S_PASS);
  wire                last_frame = (frm_cnt == FCW'(NUM_FRAMES - 1));

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_SEARCH;
      ph          <= P_IDLE;
      pre_sr      <= '0;
      len_sh      <= '0;
      len_cnt     <= '0;
      pay_cnt     <= '0;
      frm_cnt     <= '0;
      fwd_bit     <= 1'b1;
      frame_valid <= 1'b0;
      frame_data  <= '0;
      len_count   <= '0;
      done        <= 1'b0;
      frame_err   <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (reconf_req) begin
        st        <= chain_en ? S_SEARCH : S_LOCK;
        ph        <= P_IDLE;
        pre_sr    <= '0;
        len_cnt   <= '0;
        pay_cnt   <= '0;
        frm_cnt   <= '0;
        fwd_bit   <= 1'b1;
        done      <= 1'b0;
        frame_err <= 1'b0;
      end else begin
        fwd_bit <= pass_now ? tdi : 1'b1;
        case (st)
          S_SEARCH: begin
            pre_sr <= pre_next[PRE_BITS-2:0];
            if (pre_next == PREAMBLE) begin
              st      <= S_LEN;
              len_cnt <= '0;
            end
          end
          S_LEN: begin
            len_sh  <= {len_sh[LEN_BITS-3:0], tdi};
            len_cnt <= len_cnt + LCW'(1);
            if (len_cnt == LCW'(LEN_BITS - 1)) begin
              len_count <= {len_sh, tdi};
              st        <= S_FRAME;
              ph        <= P_IDLE;
            end
          end
          S_FRAME: begin
            case (ph)
              P_IDLE:  if (!tdi) ph <= P_START;
              P_START: begin
                if (tdi) begin
                  ph      <= P_PAY;
                  pay_cnt <= '0;
                end else begin
                  st        <= S_ERR;
                  frame_err <= 1'b1;
                end
              end
              P_PAY: begin
                frame_data <= {frame_data[FRAME_BITS-2:0], tdi};
                pay_cnt    <= pay_cnt + PCW'(1);
                if (pay_cnt == PCW'(FRAME_BITS - 1)) ph <= P_STOP0;
              end
              P_STOP0: begin
                if (tdi) ph <= P_STOP1;
                else begin
                  st        <= S_ERR;
                  frame_err <= 1'b1;
                end
              end
              P_STOP1: begin
                if (tdi) begin
                  frame_valid <= 1'b1;
                  ph          <= P_IDLE;
                  frm_cnt     <= frm_cnt + FCW'(1);
                  if (last_frame) begin
                    done <= 1'b1;
                    st   <= S_PASS;
                  end
                end else begin
                  st        <= S_ERR;
                  frame_err <= 1'b1;
                end
              end
              default: ph <= P_IDLE;
            endcase
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) tdo_q <= 1'b1;
    else        tdo_q <= fwd_bit;
  end

  assign tdo = tdo_q;
endmodule

// File: rtl/cfg_chain_fwd_chk.sv
module cfg_chain_fwd_chk (
  input logic tck,
  input logic rst_n,
  input logic reconf_req,
  input logic tdi,
  input logic tdo,
  input logic frame_valid,
  input logic done,
  input logic frame_err
);
  assert_valid_pulse_R6: assert property (@(posedge tck) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  assert_done_hold_R7: assert property (@(posedge tck) disable iff (!rst_n)
    (done && !reconf_req) |=> done);

  // R2: one-period latency of a forwarded bit
  assert_pass_through_R7: assert property (@(posedge tck) disable iff (!rst_n)
    (done && $past(done)) |-> (tdo == $past(tdi)));

  assert_err_sticky_R8: assert property (@(posedge tck) disable iff (!rst_n)
    (frame_err && !reconf_req) |=> frame_err);

  assert_err_tdo_high_R8: assert property (@(posedge tck) disable iff (!rst_n)
    (frame_err && $past(frame_err)) |-> tdo);

  assert_err_no_valid_R8: assert property (@(posedge tck) disable iff (!rst_n)
    frame_err |-> !frame_valid);

  assert_err_not_done_R8: assert property (@(posedge tck) disable iff (!rst_n)
    frame_err |-> !done);
endmodule

bind cfg_chain_fwd cfg_chain_fwd_chk u_chk (
  .tck(tck), .rst_n(rst_n), .reconf_req(reconf_req), .tdi(tdi), .tdo(tdo),
  .frame_valid(frame_valid), .done(done), .frame_err(frame_err)
);

// File: tb/sim_cfg_chain_fwd.sv
module sim_cfg_chain_fwd;
  localparam int FB = 16;
  localparam int LB = 24;

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic chain_en = 1'b0;
  logic reconf = 1'b0;
  logic tdi = 1'b1;
  logic t01, t12, t2o;
  logic [2:0] fv, dn, fe;
  logic [FB-1:0] fd [3];
  logic [LB-1:0] lc [3];

  always #5 tck = ~tck;

  cfg_chain_fwd #(.FRAME_BITS(FB), .NUM_FRAMES(2)) u0 (
    .tck(tck), .rst_n(rst_n), .chain_en(chain_en), .reconf_req(reconf), .tdi(tdi), .tdo(t01),
    .frame_valid(fv[0]), .frame_data(fd[0]), .len_count(lc[0]), .done(dn[0]), .frame_err(fe[0]));
  cfg_chain_fwd #(.FRAME_BITS(FB), .NUM_FRAMES(3)) u1 (
    .tck(tck), .rst_n(rst_n), .chain_en(chain_en), .reconf_req(reconf), .tdi(t01), .tdo(t12),
    .frame_valid(fv[1]), .frame_data(fd[1]), .len_count(lc[1]), .done(dn[1]), .frame_err(fe[1]));
  cfg_chain_fwd #(.FRAME_BITS(FB), .NUM_FRAMES(1)) u2 (
    .tck(tck), .rst_n(rst_n), .chain_en(chain_en), .reconf_req(reconf), .tdi(t12), .tdo(t2o),
    .frame_valid(fv[2]), .frame_data(fd[2]), .len_count(lc[2]), .done(dn[2]), .frame_err(fe[2]));

  int errors = 0;
  int checks = 0;
  logic sb [0:1023];
  logic sm [0:1023];
  int sn;
  logic [FB-1:0] exp_data [3][4];
  int rx [3];
  logic [2:0] fv_prev;
  logic prev_exp, prev_m, prev_chk;
  int run_mode;
  logic [LB-1:0] cur_len;

  function automatic int n_of(int d);
    return (d == 0) ? 2 : ((d == 1) ? 3 : 1);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic sample();
    if (prev_chk)
      chk(t01 === prev_exp, prev_m ? "R4" : "R2", "u0 tdo", t01, prev_exp);
    for (int d = 0; d < 3; d++) begin
      chk(!(fv[d] && fv_prev[d]), "R6", "strobe width", fv[d], 0);
      if (fv[d]) begin
        chk(run_mode == 0 && rx[d] < n_of(d), "R5", "unexpected frame", rx[d], n_of(d));
        if (run_mode == 0 && rx[d] < n_of(d))
          chk(fd[d] === exp_data[d][rx[d]], "R5", "frame payload", fd[d], exp_data[d][rx[d]]);
        if (d > 0) chk(dn[d-1] === 1'b1, "R4", "upstream done before frame", dn[d-1], 1);
        rx[d]++;
      end
    end
    fv_prev = fv;
  endtask

  task automatic push(input logic b, input logic m);
    sb[sn] = b;
    sm[sn] = m;
    sn++;
  endtask

  task automatic build(input int mode);
    logic m;
    logic [7:0] pre = 8'b1111_0010;
    logic [7:0] decoy = 8'b1111_0110;
    sn = 0;
    run_mode = mode;
    cur_len = LB'($urandom);
    m = (mode == 3);
    for (int i = 0; i < 3 + int'($urandom % 4); i++) push(1'b1, m);
    for (int i = 7; i >= 0; i--) push(decoy[i], m);
    for (int i = 0; i < 3; i++) push(1'b1, m);
    for (int i = 7; i >= 0; i--) push(pre[i], m);
    for (int i = LB - 1; i >= 0; i--) push(cur_len[i], m);
    m = 1'b1;
    for (int d = 0; d < 3; d++) begin
      for (int k = 0; k < n_of(d); k++) begin
        exp_data[d][k] = FB'($urandom);
        for (int g = 0; g < int'($urandom % 3); g++) push(1'b1, m);
        push(1'b0, m);
        push((mode == 2 && d == 0 && k == 0) ? 1'b0 : 1'b1, m);
        for (int i = FB - 1; i >= 0; i--) push(exp_data[d][k][i], m);
        push(1'b1, m);
        push((mode == 1 && d == 0 && k == 0) ? 1'b0 : 1'b1, m);
      end
      if (d == 0 && mode == 0) m = 1'b0;
    end
    for (int i = 0; i < 12; i++) push(1'($urandom), m);
    for (int i = 0; i < 4; i++) push(1'b1, m);
  endtask

  task automatic send_stream();
    for (int i = 0; i < sn; i++) begin
      @(negedge tck);
      #1;
      sample();
      tdi = sb[i];
      prev_exp = sm[i] ? 1'b1 : sb[i];
      prev_m = sm[i];
      prev_chk = 1'b1;
    end
    @(negedge tck);
    #1;
    sample();
    prev_chk = 1'b0;
  endtask

  task automatic clear_rx();
    for (int d = 0; d < 3; d++) rx[d] = 0;
    fv_prev = '0;
  endtask

  task automatic reconf_pulse(input logic en);
    @(negedge tck);
    #1;
    sample();
    chain_en = en;
    reconf = 1'b1;
    tdi = 1'b1;
    prev_chk = 1'b0;
    @(negedge tck);
    #1;
    reconf = 1'b0;
    clear_rx();
    chk(t01 === 1'b1 && dn == 3'b000 && fe == 3'b000, "R9", "state after request",
        {t01, dn, fe}, 8'h40);
  endtask

  task automatic run_good(input string tag);
    clear_rx();
    build(0);
    send_stream();
    for (int d = 0; d < 3; d++) begin
      chk(rx[d] == n_of(d), "R5", {tag, " frame count"}, rx[d], n_of(d));
      chk(dn[d] === 1'b1, "R7", {tag, " done"}, dn[d], 1);
      chk(fe[d] === 1'b0, "R5", {tag, " no error"}, fe[d], 0);
      chk(lc[d] === cur_len, "R3", {tag, " length word"}, lc[d], cur_len);
    end
  endtask

  initial begin
    void'($urandom(32'd1357));
    prev_chk = 1'b0;
    prev_exp = 1'b1;
    prev_m = 1'b0;
    clear_rx();
    repeat (3) @(negedge tck);
    #1;
    chk(t01 === 1'b1 && t2o === 1'b1, "R1", "tdo in reset", {t01, t2o}, 3);
    chk(dn === 3'b000 && fe === 3'b000 && fv === 3'b000, "R1", "flags in reset",
        {dn, fe, fv}, 0);
    rst_n = 1'b1;
    @(negedge tck);
    #1;
    chk(t01 === 1'b1 && dn === 3'b000, "R1", "after release", {t01, dn}, 8);

    run_good("first");
    reconf_pulse(1'b1);
    run_good("enabled restart R9");

    reconf_pulse(1'b0);
    build(3);
    send_stream();
    for (int d = 0; d < 3; d++) begin
      chk(rx[d] == 0 && dn[d] === 1'b0, "R9", "locked device silent", rx[d], 0);
    end
    chk(t2o === 1'b1, "R9", "locked chain end tdo", t2o, 1);

    reconf_pulse(1'b1);
    run_good("after lock");

    reconf_pulse(1'b1);
    clear_rx();
    build(1);
    send_stream();
    chk(fe[0] === 1'b1, "R8", "stop error flag", fe[0], 1);
    chk(dn[0] === 1'b0, "R8", "stop error done", dn[0], 0);
    for (int d = 0; d < 3; d++) chk(rx[d] == 0, "R8", "no frames after error", rx[d], 0);

    @(negedge tck);
    #2;
    rst_n = 1'b0;
    #1;
    chk(fe === 3'b000 && dn === 3'b000 && fv === 3'b000, "R10", "async clear",
        {fe, dn, fv}, 0);
    chk(t01 === 1'b1, "R10", "async tdo", t01, 1);
    @(negedge tck);
    #2;
    rst_n = 1'b1;
    prev_chk = 1'b0;

    clear_rx();
    build(2);
    send_stream();
    chk(fe[0] === 1'b1, "R8", "start error flag", fe[0], 1);
    chk(dn[0] === 1'b0 && rx[0] == 0, "R8", "start error silent", rx[0], 0);

    @(negedge tck);
    #2;
    rst_n = 1'b0;
    @(negedge tck);
    #2;
    rst_n = 1'b1;
    prev_chk = 1'b0;
    run_good("after reset R10");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors + 1, checks + 1);
    $finish;
  end
endmodule